// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a three-wire stereo PCM stream (bit clock, word clock and serial data) into a pair of parallel 18-bit samples, one pair per audio frame. A static format input picks the framing. In right-justified mode each word ends on the bit slot just before the word-clock transition. In I2S mode each word starts one bit clock after the transition. All three stream wires are treated as slow inputs. They are synchronised into the system clock domain, and only the bit-clock rising edges found there are acted on.

In right-justified mode the receiver measures each word-clock period in bit clocks. A period of exactly 32 bit clocks marks the stream as packed 16-bit, where each word fills its half frame. Any other length keeps the native 18-bit decoding. In I2S mode the first 18 bits after the MSB slot form the sample. Longer words lose their low bits, and shorter words come out with zeros at the bottom, so the sign bit always lands on bit 17. After the right word of every frame completes, both samples are presented together with a one-cycle valid strobe.

Top module: `audioSerialRx`

## Requirements
- R1: While reset is asserted and after its release, both sample outputs read zero and the valid strobe is low until a full frame has been received.
- R2: With the format input low (right-justified), each half's sample is the last 18 bits sampled before the word-clock transition that ends the half, MSB first. Earlier bit slots of the half are ignored. The left sample is the half with the word clock high.
- R3: In right-justified mode, if the previous complete word-clock period (rising edge to rising edge) held exactly 32 bit-clock rising edges, each half carries a 16-bit word. The output is that word placed in bits 17..2, and bits 1..0 are zero.
- R4: In right-justified mode, any other previous period length, and the first period after reset, falls back to 18-bit decoding as in R2.
- R5: With the format input high (I2S), the MSB is the bit sampled on the bit-clock rising edge after the one where the new word-clock level is first seen. The left sample is the half with the word clock low. A 16-bit word appears in bits 17..2, with bits 1..0 taken from the next two slots, which carry zeros.
- R6: In I2S mode only the first 18 bit slots starting at the MSB slot are kept. A 20-bit word yields its upper 18 bits, and all later slots are ignored.
- R7: The valid strobe is high for exactly one system-clock cycle per frame, a few cycles after the right word completes. Both samples change only in that cycle and are held otherwise.
- R8: Serial data and word clock are taken only at bit-clock rising edges. Data changes later in the bit-clock high phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Synchronous active-low reset |
| bitClk | input | 1 | Serial bit clock |
| wordClk | input | 1 | Word (channel) clock |
| serData | input | 1 | Serial audio data |
| fmtI2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| leftSample | output | 18 | Left channel sample, two's complement |
| rightSample | output | 18 | Right channel sample, two's complement |
| sampleValid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
Two events share a single system-clock cycle on every word-clock transition. The bit sampled at the transition is shifted in, and in I2S mode it is the final slot of the word that closes there. In that same cycle the closing word is captured and the next word's collection restarts. In right-justified mode the period length is also re-evaluated in that cycle, while the closing right word still decodes under the previous period's decision. The bench provokes this by changing frame lengths between 32 and other values mid-stream, and by using I2S halves whose last word bit falls exactly on the transition slot. It judges by comparing every reconstructed pair with values computed from the words it sent, and it skips only the first frame after each length change.

// File: rtl/audRxPkg.sv
package audRxPkg;

  // Strobes and mode bits passed from control to datapath
  typedef struct packed {
    logic shift;       // a bit-clock rising edge was seen this cycle
    logic dataBit;     // serial bit sampled at that edge
    logic wordEnd;     // the edge also carried a word-clock transition
    logic endLeft;     // the closing word belongs to the left channel
    logic endRight;    // the closing word belongs to the right channel
    logic packedWord;  // right-justified words are 16 bits wide
    logic i2s;         // I2S framing selected
  } rxStrobeT;

endpackage

// File: rtl/audRxSync.sv
module audRxSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/audRxCtrl.sv
module audRxCtrl
  import audRxPkg::*;
#(
  parameter int PACK_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitClk,
  input  logic     wordClk,
  input  logic     serData,
  input  logic     fmtI2s,
  output rxStrobeT strb
);

  localparam logic [CNT_W-1:0] PACK_LEN = CNT_W'(2 * PACK_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

  logic [3:0] syncOut;
  logic bckS, wckS, dinS, fmtS;
  logic bckQ2, wckPrev, started, periodSeen, packedMode, leftSeen;
  logic [CNT_W-1:0] periodCnt;
  logic bitTick, wordEdge, riseEdge, endLeft;

  audRxSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClk, wordClk, serData, fmtI2s}),
    .dout (syncOut)
  );

  assign {bckS, wckS, dinS, fmtS} = syncOut;

  assign bitTick  = bckS & ~bckQ2;
  assign wordEdge = bitTick & started & (wckS ^ wckPrev);
  assign riseEdge = wordEdge & wckS;
  // Left ends on falling word clock (right-justified) or rising (I2S)
  assign endLeft  = wordEdge & (fmtS ? wckS : ~wckS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckQ2      <= 1'b0;
      wckPrev    <= 1'b0;
      started    <= 1'b0;
      periodSeen <= 1'b0;
      packedMode <= 1'b0;
      leftSeen   <= 1'b0;
      periodCnt  <= '0;
    end else begin
      bckQ2 <= bckS;
      if (bitTick) begin
        wckPrev <= wckS;
        started <= 1'b1;
        if (riseEdge) begin
          if (periodSeen) packedMode <= (periodCnt == PACK_LEN);
          periodSeen <= 1'b1;
          periodCnt  <= CNT_ONE;
        end else if (periodCnt != CNT_SAT) begin
          periodCnt <= periodCnt + CNT_ONE;
        end
      end
      if (endLeft) leftSeen <= 1'b1;
    end
  end

  always_comb begin
    strb.shift      = bitTick;
    strb.dataBit    = dinS;
    strb.wordEnd    = wordEdge;
    strb.endLeft    = endLeft;
    strb.endRight   = wordEdge & ~endLeft & leftSeen;
    strb.packedWord = packedMode & ~fmtS;
    strb.i2s        = fmtS;
  end

  // R3: packed decoding is only ever chosen after a full period was measured
  a_r3_packed_after_period: assert property (@(posedge clk) disable iff (!rstN)
    packedMode |-> periodSeen);

  // R8: word boundaries are recognised only at bit-clock rising edges
  a_r8_edge_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordEnd |-> (bckS && !bckQ2));

  // R4: the packed decision changes only one cycle after a bit-clock edge
  a_r4_mode_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(packedMode) |-> $past(bckS && !bckQ2));

endmodule

// File: rtl/audRxData.sv
module audRxData
  import audRxPkg::*;
#(
  parameter int WORD_W = 18,
  parameter int PACK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobeT          strb,
  output logic [WORD_W-1:0] leftOut,
  output logic [WORD_W-1:0] rightOut,
  output logic              validOut
);

  localparam int FILL_W = $clog2(WORD_W + 1);
  localparam logic [FILL_W-1:0] FILL_MAX  = FILL_W'(WORD_W);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(WORD_W - 1);
  localparam logic [FILL_W-1:0] FILL_ONE  = FILL_W'(1);

  logic [WORD_W-1:0] shiftReg, acc, accDone, placeMask, rjWord, doneWord, leftHold;
  logic [FILL_W-1:0] fillCnt;

  // Right-justified word: tail of the shift register
  assign rjWord = strb.packedWord ?
                  {shiftReg[PACK_W-1:0], {(WORD_W-PACK_W){1'b0}}} : shiftReg;

  // I2S word: MSB-first accumulator that includes the current bit
  always_comb begin
    placeMask = '0;
    if (fillCnt < FILL_MAX) placeMask[FILL_LAST - fillCnt] = 1'b1;
    accDone = strb.dataBit ? (acc | placeMask) : acc;
  end

  assign doneWord = strb.i2s ? accDone : rjWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      acc      <= '0;
      fillCnt  <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      validOut <= 1'b0;
    end else begin
      if (strb.shift) begin
        shiftReg <= {shiftReg[WORD_W-2:0], strb.dataBit};
        if (strb.wordEnd) begin
          acc     <= '0;
          fillCnt <= '0;
        end else begin
          acc <= accDone;
          if (fillCnt < FILL_MAX) fillCnt <= fillCnt + FILL_ONE;
        end
      end
      if (strb.endLeft) leftHold <= doneWord;
      validOut <= strb.endRight;
      if (strb.endRight) begin
        leftOut  <= leftHold;
        rightOut <= doneWord;
      end
    end
  end

  // R6: the accumulator never counts past one output word
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= FILL_MAX);

  // R7: valid is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validOut |=> !validOut);

  // R7: outputs hold between strobes
  a_r7_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> ($stable(leftOut) && $stable(rightOut)));

  // R7: a strobe always follows a completed right word
  a_r7_valid_after_right: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> $past(strb.endRight));

  // R3: packed left words carry zero low bits
  a_r3_packed_zero_lsb: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endLeft && strb.packedWord && !strb.i2s) |=> (leftHold[WORD_W-PACK_W-1:0] == '0));

endmodule

// File: rtl/audioSerialRx.sv
module audioSerialRx
  import audRxPkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int PACK_W      = 16,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              wordClk,
  input  logic              serData,
  input  logic              fmtI2s,
  output logic [WORD_W-1:0] leftSample,
  output logic [WORD_W-1:0] rightSample,
  output logic              sampleValid
);

  rxStrobeT strb;

  audRxCtrl #(.PACK_W(PACK_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClk  (bitClk),
    .wordClk (wordClk),
    .serData (serData),
    .fmtI2s  (fmtI2s),
    .strb    (strb)
  );

  audRxData #(.WORD_W(WORD_W), .PACK_W(PACK_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .leftOut  (leftSample),
    .rightOut (rightSample),
    .validOut (sampleValid)
  );

endmodule

// File: tb/sim_audioSerialRx.sv
module sim_audioSerialRx;

  logic clk = 1'b0;
  logic rstN, bitClk, wordClk, serData, fmtI2s;
  logic [17:0] leftSample, rightSample;
  logic sampleValid;

  always #4 clk = ~clk;

  audioSerialRx u0 (
    .clk         (clk),
    .rstN        (rstN),
    .bitClk      (bitClk),
    .wordClk     (wordClk),
    .serData     (serData),
    .fmtI2s      (fmtI2s),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .sampleValid (sampleValid)
  );

  int total = 0;
  int bad = 0;
  int holdErr = 0;
  int prevSlots = 0;
  logic carry = 1'b0;
  logic [17:0] lastL = '0, lastR = '0;

  logic [17:0] qL[$];
  logic [17:0] qR[$];
  bit          qC[$];
  string       qT[$];

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare every presented pair with the queued expectation (R7)
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (sampleValid) begin
        if (qL.size() == 0) begin
          total++; bad++;
          $display("FAIL R7 unexpected strobe actual=1 expected=0");
        end else begin
          logic [17:0] eL, eR;
          bit c;
          string t;
          eL = qL.pop_front(); eR = qR.pop_front(); c = qC.pop_front(); t = qT.pop_front();
          if (c) begin
            chk({t, " left"}, leftSample, eL);
            chk({t, " right"}, rightSample, eR);
          end
        end
        lastL = leftSample;
        lastR = rightSample;
      end else if (leftSample !== lastL || rightSample !== lastR) begin
        holdErr++;
      end
    end
  end

  // One bit slot; data is disturbed late in the high phase (R8)
  task automatic slot(input logic b, input logic w);
    bitClk = 1'b0; serData = b; wordClk = w;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (2) @(negedge clk);
    serData = 1'($urandom);
    repeat (2) @(negedge clk);
  endtask

  task automatic doReset(input logic fmt, input logic idle);
    rstN = 1'b0; bitClk = 1'b0; wordClk = idle; serData = 1'b0; fmtI2s = fmt;
    repeat (5) @(negedge clk);
    chk("R1 reset left", leftSample, 18'h0);
    chk("R1 reset right", rightSample, 18'h0);
    chk("R1 reset valid", {17'h0, sampleValid}, 18'h0);
    qL.delete(); qR.delete(); qC.delete(); qT.delete();
    lastL = '0; lastR = '0; prevSlots = 0; carry = 1'b0;
    rstN = 1'b1;
    slot(1'b0, idle);
    slot(1'b0, idle);
  endtask

  task automatic rjHalf(input logic lvl, input logic [17:0] word, input int slots);
    int wlen;
    wlen = (slots == 16) ? 16 : 18;
    for (int i = 0; i < slots; i++) begin
      if (i < slots - wlen) slot(1'($urandom), lvl);
      else slot(word[17 - (i - (slots - wlen))], lvl);
    end
  endtask

  task automatic rjFrame(input logic [17:0] l, input logic [17:0] r, input int slots);
    string tag;
    rjHalf(1'b1, l, slots);
    rjHalf(1'b0, r, slots);
    tag = (slots == 16) ? "R3 R8" : ((slots == 32) ? "R4 R8" : "R2 R8");
    qL.push_back((slots == 16) ? {l[17:2], 2'b00} : l);
    qR.push_back((slots == 16) ? {r[17:2], 2'b00} : r);
    qC.push_back(prevSlots == slots);
    qT.push_back(tag);
    prevSlots = slots;
  endtask

  task automatic i2sHalf(input logic lvl, input logic [23:0] w, input int wlen, input int slots);
    slot(carry, lvl);
    for (int p = 1; p <= slots; p++) begin
      logic v;
      if (p <= wlen) v = w[wlen - p];
      else if (p <= 18) v = 1'b0;
      else v = 1'($urandom);
      if (p < slots) slot(v, lvl);
      else carry = v;
    end
  endtask

  function automatic logic [17:0] i2sExp(input logic [23:0] w, input int wlen);
    if (wlen >= 18) return w[wlen - 1 -: 18];
    return {w[15:0], 2'b00};
  endfunction

  task automatic i2sFrame(input logic [23:0] l, input logic [23:0] r, input int wlen, input int slots);
    logic [23:0] lm, rm;
    lm = l & ((24'h1 << wlen) - 24'h1);
    rm = r & ((24'h1 << wlen) - 24'h1);
    i2sHalf(1'b0, lm, wlen, slots);
    i2sHalf(1'b1, rm, wlen, slots);
    qL.push_back(i2sExp(lm, wlen));
    qR.push_back(i2sExp(rm, wlen));
    qC.push_back(1'b1);
    qT.push_back((wlen == 20) ? "R6 R8" : "R5 R8");
  endtask

  // Closing transition so the last frame is delivered, then count strobes (R7)
  task automatic endBlock(input logic lvl);
    slot(carry, lvl);
    slot(1'b0, lvl);
    slot(1'b0, lvl);
    repeat (10) @(negedge clk);
    chk("R7 one strobe per frame", 18'(qL.size()), 18'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int seedVal;
    seedVal = $urandom(32'd2024);
    rstN = 1'b0;

    // Right-justified framing
    doReset(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) rjFrame(18'($urandom), 18'($urandom), 24);
    rjFrame(18'h3FFFF, 18'h00001, 24);
    for (int k = 0; k < 5; k++) rjFrame(18'($urandom), 18'($urandom), 16);
    rjFrame(18'h20000, 18'h1FFFC, 16);
    for (int k = 0; k < 4; k++) rjFrame(18'($urandom), 18'($urandom), 32);
    rjFrame(18'h20001, 18'h1FFFF, 32);
    for (int k = 0; k < 3; k++) rjFrame(18'($urandom), 18'($urandom), 18);
    endBlock(1'b1);

    // I2S framing
    doReset(1'b1, 1'b1);
    for (int k = 0; k < 4; k++) i2sFrame(24'($urandom), 24'($urandom), 16, 16);
    i2sFrame(24'h8000, 24'h7FFF, 16, 16);
    for (int k = 0; k < 4; k++) i2sFrame(24'($urandom), 24'($urandom), 20, 24);
    i2sFrame(24'h80001, 24'h7FFFE, 20, 24);
    for (int k = 0; k < 3; k++) i2sFrame(24'($urandom), 24'($urandom), 18, 32);
    for (int k = 0; k < 3; k++) i2sFrame(24'($urandom), 24'($urandom), 20, 20);
    endBlock(1'b0);

    total++;
    if (holdErr != 0) begin
      bad++;
      $display("FAIL R7 outputs changed without strobe actual=%0d expected=0", holdErr);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule